// File: doc/BRIEF.md
# Cluster Coherency Control Register Block

This block is the small register file that sits in front of the coherency controller of a multiprocessor cluster. A host reaches it through a plain memory-mapped port. The port carries a byte offset, write data, an access size in bytes, separate read and write strobes, and read data. The block holds three things. The first is a single enable bit. The second is a read-only configuration word that shows how many cores the cluster was built with. The third is a 32-bit power-status word. That word can be updated through any of four byte offsets, and each write touches 1, 2 or 4 bytes.

Some offsets are decoded but do nothing: the invalidate command and the two address-filter bounds. Any other offset reads as zero and is flagged as an error. Read data and the error flag are registered. They appear on the cycle after the strobe and fall back to zero when no access took place.

Top module: `snoop_ctl_regs`

## Requirements
- R1: A synchronous active-high reset clears the enable bit and the power-status word to zero. After reset, reads at offsets 0x00 and 0x08 return zero.
- R2: A legal-size write to offset 0x00 stores only bit 0 of the write data as the enable bit. Reading offset 0x00 returns that bit in bit 0 and zeros elsewhere.
- R3: A read at offset 0x04 returns ((1<<NUM_CORES)-1)<<4 ORed with NUM_CORES-1. With the default NUM_CORES of 1 this gives 0x10. Writes to 0x04 change neither the enable bit nor the status word.
- R4: A read at offset 0x08+k (k = 0..3) returns the status word logically shifted right by 8*k bits.
- R5: A write at offset 0x08+k builds a mask from the size port: 0xFF for 1, 0xFFFF for 2, 0xFFFFFFFF for 4. It clears the masked field at bit 8*k, then inserts the write data ANDed with the mask at that position. Bits shifted past bit 31 are lost.
- R6: The size port gives the access width in bytes, and only the values 1, 2 and 4 are legal. A write with any other size changes no state. Any access with an illegal size returns read data zero and raises the error flag.
- R7: Offsets 0x0C, 0x40 and 0x44 read as zero, ignore writes and raise no error.
- R8: An access to any offset not named in R2 to R7, including 0x50 and 0x54, reads as zero and raises the error flag.
- R9: Read data and the error flag are registered and appear in the cycle after the strobe. In a cycle after a clock with no strobe, the read data is zero and the error flag is low. An error pulse lasts one cycle per faulty access.
- R10: When the read and write strobes are both high, the write takes effect and the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte offset of the access |
| size | input | 3 | Access width in bytes (1, 2 or 4 legal) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err | output | 1 | Registered one-cycle error pulse |

## Verification
The bench builds two copies from one stimulus stream. One uses NUM_CORES of 3, so its configuration word (0x72) has both a multi-bit core mask and a nonzero count field. The other keeps the default of 1, which checks the 0x10 value. Random traffic mixes every offset with legal and illegal sizes, so that high-lane writes of size 2 and 4 exercise the discarded overflow bits. Directed cases cover writes that run off the top of the word and a simultaneous read and write.

// File: rtl/snp_regs_pkg.sv
package snp_regs_pkg;
  localparam int DATA_W = 32;
  localparam int SIZE_W = 3;
  localparam int LANE_W = 2;

  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_CFG   = 'h04;
  localparam int OFF_STAT  = 'h08;
  localparam int OFF_INV   = 'h0C;
  localparam int OFF_FLT_S = 'h40;
  localparam int OFF_FLT_E = 'h44;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_CTRL,
    RK_CFG,
    RK_STAT,
    RK_INERT
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e          kind;
    logic               size_ok;
    logic [LANE_W-1:0]  lane;
    logic [DATA_W-1:0]  mask;
  } dec_t;
endpackage

// File: rtl/snp_decode.sv
module snp_decode
  import snp_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output dec_t              dec
);
  always_comb begin
    dec = '0;
    dec.kind = RK_NONE;
    dec.lane = addr[LANE_W-1:0];
    case (size)
      SIZE_W'(1): begin dec.size_ok = 1'b1; dec.mask = 32'h0000_00FF; end
      SIZE_W'(2): begin dec.size_ok = 1'b1; dec.mask = 32'h0000_FFFF; end
      SIZE_W'(4): begin dec.size_ok = 1'b1; dec.mask = 32'hFFFF_FFFF; end
      default:    begin dec.size_ok = 1'b0; dec.mask = '0; end
    endcase
    if (addr == ADDR_W'(OFF_CTRL))
      dec.kind = RK_CTRL;
    else if (addr == ADDR_W'(OFF_CFG))
      dec.kind = RK_CFG;
    else if ((addr >> LANE_W) == (ADDR_W'(OFF_STAT) >> LANE_W))
      dec.kind = RK_STAT;
    else if (addr == ADDR_W'(OFF_INV) || addr == ADDR_W'(OFF_FLT_S) ||
             addr == ADDR_W'(OFF_FLT_E))
      dec.kind = RK_INERT;
  end
endmodule

// File: rtl/snp_state.sv
module snp_state
  import snp_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  dec_t              dec,
  input  logic [DATA_W-1:0] wdata,
  output logic              ctrl_q,
  output logic [DATA_W-1:0] status_q
);
  localparam int SH_W = LANE_W + 3;

  logic [SH_W-1:0]   shamt;
  logic [DATA_W-1:0] field_mask;
  logic [DATA_W-1:0] field_data;

  always_comb begin
    shamt      = {dec.lane, 3'b000};
    field_mask = dec.mask << shamt;
    field_data = (wdata & dec.mask) << shamt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= 1'b0;
      status_q <= '0;
    end else if (wr_en && dec.size_ok) begin
      case (dec.kind)
        RK_CTRL: ctrl_q   <= wdata[0];
        RK_STAT: status_q <= (status_q & ~field_mask) | field_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/snp_rdport.sv
module snp_rdport
  import snp_regs_pkg::*;
#(
  parameter int NUM_CORES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  dec_t              dec,
  input  logic              ctrl_q,
  input  logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              err_q
);
  localparam logic [DATA_W-1:0] CORE_MASK = DATA_W'((1 << NUM_CORES) - 1);
  localparam logic [DATA_W-1:0] CFG_WORD  = (CORE_MASK << 4) | DATA_W'(NUM_CORES - 1);

  logic [DATA_W-1:0] rd_val;
  logic              err_nxt;

  always_comb begin
    rd_val = '0;
    if (dec.size_ok) begin
      case (dec.kind)
        RK_CTRL: rd_val = {{(DATA_W-1){1'b0}}, ctrl_q};
        RK_CFG:  rd_val = CFG_WORD;
        RK_STAT: rd_val = status_q >> {dec.lane, 3'b000};
        default: rd_val = '0;
      endcase
    end
    err_nxt = (rd_en || wr_en) && (!dec.size_ok || dec.kind == RK_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rd_en ? rd_val : '0;
      err_q   <= err_nxt;
    end
  end
endmodule

// File: rtl/snoop_ctl_regs.sv
module snoop_ctl_regs
  import snp_regs_pkg::*;
#(
  parameter int NUM_CORES = 1,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              err
);
  dec_t              dec;
  logic              ctrl_q;
  logic [DATA_W-1:0] status_q;

  snp_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (addr),
    .size (size),
    .dec  (dec)
  );

  snp_state u_state (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .dec      (dec),
    .wdata    (wdata),
    .ctrl_q   (ctrl_q),
    .status_q (status_q)
  );

  snp_rdport #(.NUM_CORES(NUM_CORES)) u_rdport (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .dec      (dec),
    .ctrl_q   (ctrl_q),
    .status_q (status_q),
    .rdata_q  (rdata),
    .err_q    (err)
  );
endmodule

// File: rtl/snoop_ctl_regs_chk.sv
module snoop_ctl_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [2:0]        size,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              err,
  input logic              ctrl_q,
  input logic [31:0]       status_q
);
  logic legal_sz;
  logic mapped;
  assign legal_sz = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
  assign mapped   = (addr == ADDR_W'('h00)) || (addr == ADDR_W'('h04)) ||
                    (addr == ADDR_W'('h08)) || (addr == ADDR_W'('h09)) ||
                    (addr == ADDR_W'('h0A)) || (addr == ADDR_W'('h0B)) ||
                    (addr == ADDR_W'('h0C)) || (addr == ADDR_W'('h40)) ||
                    (addr == ADDR_W'('h44));

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (ctrl_q == 1'b0 && status_q == 32'h0)); // R1

  AST_CTRL_BIT0: assert property (@(posedge clk) disable iff (rst)
    (wr_en && legal_sz && addr == ADDR_W'('h00)) |=> (ctrl_q == $past(wdata[0]))); // R2

  AST_CFG_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'('h04)) |=> ($stable(ctrl_q) && $stable(status_q))); // R3

  AST_BAD_SIZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !legal_sz) |=> ($stable(ctrl_q) && $stable(status_q) && err)); // R6

  AST_UNMAPPED_ERR: assert property (@(posedge clk) disable iff (rst)
    ((rd_en || wr_en) && !mapped) |=> (err && rdata == 32'h0)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !wr_en) |=> (!err && rdata == 32'h0)); // R9
endmodule

bind snoop_ctl_regs snoop_ctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .addr     (addr),
  .size     (size),
  .wdata    (wdata),
  .rdata    (rdata),
  .err      (err),
  .ctrl_q   (ctrl_q),
  .status_q (status_q)
);

// File: tb/snoop_ctl_regs_tb.sv
`timescale 1ns/1ps
module snoop_ctl_regs_tb;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [2:0]    size = 3'd4;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata, rdata1;
  logic          err, err1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic        m_ctrl;
  logic [31:0] m_stat;

  always #2.5 clk = ~clk;

  snoop_ctl_regs #(.NUM_CORES(3), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .size(size), .wdata(wdata), .rdata(rdata), .err(err)
  );

  snoop_ctl_regs #(.ADDR_W(AW)) u_dut_one (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .size(size), .wdata(wdata), .rdata(rdata1), .err(err1)
  );

  function automatic bit f_legal(input logic [2:0] s);
    return (s == 3'd1) || (s == 3'd2) || (s == 3'd4);
  endfunction

  function automatic bit f_mapped(input logic [AW-1:0] a);
    return a == 8'h00 || a == 8'h04 || (a >= 8'h08 && a <= 8'h0C) ||
           a == 8'h40 || a == 8'h44;
  endfunction

  function automatic logic [31:0] f_read(input logic [AW-1:0] a, input logic [2:0] s,
                                         input int ncores);
    if (!f_legal(s)) return 32'h0;
    if (a == 8'h00) return {31'h0, m_ctrl};
    if (a == 8'h04) return (((32'd1 << ncores) - 32'd1) << 4) | 32'(ncores - 1);
    if (a >= 8'h08 && a <= 8'h0B) return m_stat >> (8 * int'(a - 8'h08));
    return 32'h0;
  endfunction

  function automatic logic [31:0] f_stat_wr(input logic [AW-1:0] a, input logic [2:0] s,
                                            input logic [31:0] d);
    logic [63:0] msk;
    int          sh;
    msk = (s == 3'd1) ? 64'hFF : (s == 3'd2) ? 64'hFFFF : 64'hFFFF_FFFF;
    sh  = 8 * int'(a - 8'h08);
    return 32'(({32'h0, m_stat} & ~(msk << sh)) | (({32'h0, d} & msk) << sh));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access: drive at negedge, sample just after the capturing posedge.
  task automatic op(input bit r, input bit w, input logic [AW-1:0] a,
                    input logic [2:0] s, input logic [31:0] d, input string req);
    logic [31:0] exp_rd, exp_rd1;
    logic        exp_err;
    @(negedge clk);
    rd_en = r; wr_en = w; addr = a; size = s; wdata = d;
    exp_rd  = r ? f_read(a, s, 3) : 32'h0;
    exp_rd1 = r ? f_read(a, s, 1) : 32'h0;
    exp_err = (r || w) && (!f_legal(s) || !f_mapped(a));
    if (w && f_legal(s)) begin
      if (a == 8'h00) m_ctrl = d[0];
      else if (a >= 8'h08 && a <= 8'h0B) m_stat = f_stat_wr(a, s, d);
    end
    @(posedge clk);
    #1;
    check({req, " rdata"}, rdata, exp_rd);
    check({req, " err"}, {31'h0, err}, {31'h0, exp_err});
    if (r && a == 8'h04) check({req, " rdata default cores"}, rdata1, exp_rd1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int dummy;
    dummy  = $urandom(32'h5C0F);
    m_ctrl = 1'b0;
    m_stat = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    op(1, 0, 8'h00, 3'd4, 0, "R1 ctrl after reset");
    op(1, 0, 8'h08, 3'd4, 0, "R1 status after reset");
    // R2: only bit 0 kept
    op(0, 1, 8'h00, 3'd4, 32'hFFFF_FFFE, "R2 write even");
    op(1, 0, 8'h00, 3'd4, 0, "R2 read zero");
    op(0, 1, 8'h00, 3'd1, 32'h0000_0003, "R2 write odd");
    op(1, 0, 8'h00, 3'd2, 0, "R2 read one");
    // R3: config word, read-only
    op(1, 0, 8'h04, 3'd4, 0, "R3 config");
    op(0, 1, 8'h04, 3'd4, 32'hFFFF_FFFF, "R3 write ignored");
    op(1, 0, 8'h04, 3'd4, 0, "R3 config again");
    op(1, 0, 8'h00, 3'd4, 0, "R3 ctrl untouched");
    // R5/R4: lane writes and shifted reads
    op(0, 1, 8'h08, 3'd4, 32'hDEAD_BEEF, "R5 full word");
    op(1, 0, 8'h0B, 3'd1, 0, "R4 lane3 read");
    op(0, 1, 8'h0B, 3'd2, 32'h0000_1234, "R5 overflow dropped");
    op(1, 0, 8'h08, 3'd4, 0, "R5 after overflow");
    op(0, 1, 8'h09, 3'd1, 32'hFFFF_FF55, "R5 byte lane1");
    op(1, 0, 8'h09, 3'd4, 0, "R4 lane1 read");
    op(0, 1, 8'h0A, 3'd4, 32'h89AB_CDEF, "R5 word at lane2");
    op(1, 0, 8'h0A, 3'd4, 0, "R4 lane2 read");
    // R6: illegal sizes
    op(0, 1, 8'h08, 3'd3, 32'h1111_1111, "R6 bad size write");
    op(1, 0, 8'h08, 3'd4, 0, "R6 status unchanged");
    op(0, 1, 8'h00, 3'd0, 32'h0, "R6 bad size ctrl");
    op(1, 0, 8'h00, 3'd4, 0, "R6 ctrl unchanged");
    op(1, 0, 8'h04, 3'd7, 0, "R6 bad size read");
    // R7: inert offsets
    op(1, 1, 8'h0C, 3'd4, 32'hFFFF_FFFF, "R7 invalidate");
    op(1, 1, 8'h40, 3'd4, 32'hFFFF_FFFF, "R7 filter start");
    op(1, 1, 8'h44, 3'd4, 32'hFFFF_FFFF, "R7 filter end");
    op(1, 0, 8'h08, 3'd4, 0, "R7 status untouched");
    // R8: unmapped
    op(1, 0, 8'h50, 3'd4, 0, "R8 access ctrl");
    op(0, 1, 8'h54, 3'd4, 32'h5, "R8 nonsecure ctrl");
    op(1, 0, 8'hF0, 3'd1, 0, "R8 far offset");
    // R9: idle cycles
    op(0, 0, 8'h08, 3'd4, 0, "R9 idle");
    op(0, 0, 8'h50, 3'd0, 0, "R9 idle bad inputs");
    // R10: read and write together
    op(1, 1, 8'h08, 3'd4, 32'h0BAD_F00D, "R10 pre-write value");
    op(1, 0, 8'h08, 3'd4, 0, "R10 post-write value");

    // Random mix across R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      logic [2:0]    s;
      int            pick;
      pick = int'($urandom_range(0, 11));
      case (pick)
        0: a = 8'h00;  1: a = 8'h04;  2: a = 8'h08;  3: a = 8'h09;
        4: a = 8'h0A;  5: a = 8'h0B;  6: a = 8'h0C;  7: a = 8'h40;
        8: a = 8'h44;  9: a = 8'h50; 10: a = 8'h54;
        default: a = AW'($urandom);
      endcase
      pick = int'($urandom_range(0, 5));
      case (pick)
        0: s = 3'd1; 1: s = 3'd2; 2: s = 3'd4; 3: s = 3'd1;
        4: s = 3'd4; default: s = 3'($urandom);
      endcase
      op(bit'($urandom), bit'($urandom), a, s, $urandom, "R5 random");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule